// File: doc/BRIEF.md
# Mixed-Depth Pixel Source Selector

This block sits in the scan-out path of a frame buffer that keeps three planes read in lockstep. One plane holds an 8-bit palette index per pixel, one holds a 32-bit direct-colour word per pixel, and one holds a 32-bit control word per pixel. Each pixel arrives as one tuple of (index, direct word, control word) on a valid/ready stream. For each tuple the block picks one colour source. If the control word carries the direct tag, the colour comes from the direct word. Otherwise the index goes out on a palette lookup port and the returned colour is used.

The palette memory lives outside the block. It is a synchronous read port with an enable and a fixed latency of `PAL_LAT` enabled cycles. The direct colour travels through a delay line of the same depth, so the two sources meet at the output in input order. The output is a valid/ready stream of 32-bit pixels. A configuration input packs each pixel as RGB or as BGR. Backpressure on the output freezes the whole pipeline and the palette port together, so no pixel is lost or repeated. Address generation, including the fixed 1024-pixel line stride and the frame limit of 1024 by 768, belongs to the fetch logic upstream.

Top module: `mixpix_selector`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1 until the first tuple has passed through the pipeline.
- R2: When bits [31:24] of `in_ctrl` equal 0x03, the pixel takes the direct colour. In `in_direct`, bits [23:16] are blue, [15:8] are green and [7:0] are red.
- R3: When bits [31:24] of `in_ctrl` hold any value other than 0x03, the pixel takes the palette colour for `in_index`. In that case `in_direct` and `in_ctrl[23:0]` have no effect on the output.
- R4: Bits [31:24] of `in_direct` never affect the output pixel.
- R5: Whenever `in_ready` is 1, `pal_en` is 1 and `pal_addr` equals `in_index`. The palette port returns `pal_rgb` as {red[23:16], green[15:8], blue[7:0]}, `PAL_LAT` enabled cycles after the address is sampled.
- R6: When the output is never stalled, a tuple accepted at a clock edge appears on `out_pixel` exactly `PAL_LAT` cycles later.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. On the next cycle `out_valid` is still 1, and `out_pixel` is unchanged if `cfg_bgr` is unchanged.
- R8: Every accepted tuple produces exactly one output pixel, in acceptance order. At most `PAL_LAT` pixels are in flight at once.
- R9: With `cfg_bgr` = 0 the pixel is {8'h00, red, green, blue}. With `cfg_bgr` = 1 it is {8'h00, blue, green, red}. The packing applies to the pixel currently presented.
- R10: Bits [31:24] of `out_pixel` are 0 whenever `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_bgr | input | 1 | 1 packs the output as BGR, 0 as RGB |
| in_valid | input | 1 | Input tuple valid |
| in_ready | output | 1 | Input tuple accepted when high together with in_valid |
| in_index | input | 8 | Indexed-plane value |
| in_direct | input | 32 | Direct-colour plane word |
| in_ctrl | input | 32 | Control plane word |
| pal_en | output | 1 | Palette read enable; the palette holds its output when low |
| pal_addr | output | 8 | Palette read address |
| pal_rgb | input | 24 | Palette read data, PAL_LAT enabled cycles after the address |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_pixel | output | 32 | Packed output pixel |

## Verification
A tuple accepted at one clock edge is due on `out_pixel` after `PAL_LAT` further edges when nothing stalls. Each stall cycle pushes it back by exactly one edge. The bench drives inputs just after a falling edge and samples one time step later. At that point it decides both acceptance and output transfer, so every result is compared in the half-cycle before the edge that consumes it. A scoreboard keyed on acceptance order checks the colours. In free-running phases the bench also checks the gap in cycles between acceptance and emission. Under random backpressure it checks that a stalled pixel is held on the following cycle.

// File: rtl/mixpix_pkg.sv
package mixpix_pkg;
    localparam int CH_W = 8;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] blu;
    } rgb_t;

    typedef struct packed {
        logic live;
        logic pick_dir;
        rgb_t dir;
    } slot_t;
endpackage

// File: rtl/mixpix_classify.sv
module mixpix_classify
    import mixpix_pkg::*;
#(
    parameter logic [CH_W-1:0] TAG_VAL = 8'h03
) (
    input  logic [4*CH_W-1:0] ctrl_word,
    input  logic [4*CH_W-1:0] dir_word,
    output logic              pick_dir,
    output rgb_t              dir_rgb
);
    localparam int WORD_W = 4 * CH_W;

    logic spare_unused;
    assign spare_unused = ^{ctrl_word[WORD_W-CH_W-1:0], dir_word[WORD_W-1 -: CH_W]};

    always_comb begin
        pick_dir    = (ctrl_word[WORD_W-1 -: CH_W] == TAG_VAL);
        dir_rgb.blu = dir_word[3*CH_W-1 -: CH_W];
        dir_rgb.grn = dir_word[2*CH_W-1 -: CH_W];
        dir_rgb.red = dir_word[CH_W-1:0];
    end
endmodule

// File: rtl/mixpix_stage.sv
module mixpix_stage
    import mixpix_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  slot_t slot_in,
    output slot_t slot_out
);
    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (adv) begin
            slot_d = slot_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign slot_out = slot_q;
endmodule

// File: rtl/mixpix_pack.sv
module mixpix_pack
    import mixpix_pkg::*;
(
    input  logic              pick_dir,
    input  rgb_t              dir_rgb,
    input  rgb_t              pal_rgb,
    input  logic              bgr,
    output logic [4*CH_W-1:0] pixel
);
    rgb_t chosen;

    always_comb begin
        chosen = pick_dir ? dir_rgb : pal_rgb;
        if (bgr) begin
            pixel = {{CH_W{1'b0}}, chosen.blu, chosen.grn, chosen.red};
        end else begin
            pixel = {{CH_W{1'b0}}, chosen.red, chosen.grn, chosen.blu};
        end
    end
endmodule

// File: rtl/mixpix_selector.sv
module mixpix_selector
    import mixpix_pkg::*;
#(
    parameter int              PAL_LAT = 2,
    parameter int              IDX_W   = 8,
    parameter logic [CH_W-1:0] TAG_VAL = 8'h03
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_bgr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [4*CH_W-1:0] in_direct,
    input  logic [4*CH_W-1:0] in_ctrl,
    output logic              pal_en,
    output logic [IDX_W-1:0]  pal_addr,
    input  logic [3*CH_W-1:0] pal_rgb,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [4*CH_W-1:0] out_pixel
);
    localparam int NSLOT = PAL_LAT + 1;

    slot_t chain [NSLOT];
    slot_t head;
    slot_t tail;
    logic  advance;
    logic  head_pick;
    rgb_t  head_rgb;

    mixpix_classify #(.TAG_VAL(TAG_VAL)) u_classify (
        .ctrl_word (in_ctrl),
        .dir_word  (in_direct),
        .pick_dir  (head_pick),
        .dir_rgb   (head_rgb)
    );

    always_comb begin
        head          = '0;
        head.live     = in_valid;
        head.pick_dir = head_pick;
        head.dir      = head_rgb;
    end

    assign chain[0] = head;

    for (genvar k = 0; k < PAL_LAT; k++) begin : g_delay
        mixpix_stage u_stage (
            .clk      (clk),
            .rst      (rst),
            .adv      (advance),
            .slot_in  (chain[k]),
            .slot_out (chain[k+1])
        );
    end

    assign tail     = chain[PAL_LAT];
    assign advance  = !tail.live || out_ready;
    assign in_ready = advance;
    assign pal_en   = advance;
    assign pal_addr = in_index;
    assign out_valid = tail.live;

    mixpix_pack u_pack (
        .pick_dir (tail.pick_dir),
        .dir_rgb  (tail.dir),
        .pal_rgb  (pal_rgb),
        .bgr      (cfg_bgr),
        .pixel    (out_pixel)
    );
endmodule

// File: rtl/mixpix_sel_chk.sv
module mixpix_sel_chk #(
    parameter int PAL_LAT = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_bgr,
    input logic        in_valid,
    input logic        in_ready,
    input logic        pal_en,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_pixel
);
    int occ_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= 0;
        end else begin
            occ_q <= occ_q + int'(in_valid && in_ready) - int'(out_valid && out_ready);
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && in_ready);

    // R5
    pal_enable_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> pal_en);

    // R7
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(out_valid && !out_ready) && $stable(cfg_bgr)) |-> (out_valid && $stable(out_pixel)));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occ_q <= PAL_LAT && occ_q >= 0);

    // R8
    empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (occ_q == 0) |-> !out_valid);

    // R10
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_pixel[31:24] == 8'h00));
endmodule

bind mixpix_selector mixpix_sel_chk #(.PAL_LAT(PAL_LAT)) u_sel_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_bgr   (cfg_bgr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pal_en    (pal_en),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel)
);

// File: tb/mixpix_selector_test.sv
module mixpix_selector_test;
    localparam int PAL_LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_bgr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_index = '0;
    logic [31:0] in_direct = '0;
    logic [31:0] in_ctrl = '0;
    logic        pal_en;
    logic [7:0]  pal_addr;
    logic [23:0] pal_rgb;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_pixel;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    bit bp_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [23:0] exp_q[$];
    int          acc_q[$];
    bit          prev_stall = 0;
    logic [31:0] prev_pix = '0;
    logic        prev_bgr = 0;

    always #2.5 clk = ~clk;

    mixpix_selector #(.PAL_LAT(PAL_LAT)) uut (
        .clk(clk), .rst(rst), .cfg_bgr(cfg_bgr),
        .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
        .in_direct(in_direct), .in_ctrl(in_ctrl),
        .pal_en(pal_en), .pal_addr(pal_addr), .pal_rgb(pal_rgb),
        .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
    );

    // palette model: {red, green, blue} computed from the index
    function automatic logic [23:0] pal_of(input logic [7:0] i);
        logic [7:0] g3;
        g3 = 8'(i * 3);
        return {i, g3, ~i};
    endfunction

    logic [23:0] pl [PAL_LAT];
    always @(posedge clk) begin
        if (pal_en) begin
            pl[0] <= pal_of(pal_addr);
            for (int k = 1; k < PAL_LAT; k++) pl[k] <= pl[k-1];
        end
    end
    assign pal_rgb = pl[PAL_LAT-1];

    function automatic logic [31:0] pack(input logic [23:0] c, input logic bgr);
        return bgr ? {8'h00, c[7:0], c[15:8], c[23:16]} : {8'h00, c};
    endfunction

    function automatic logic [23:0] expect_rgb(input logic [7:0] idx, input logic [31:0] dw,
                                               input logic [31:0] cw);
        if (cw[31:24] == 8'h03) return {dw[7:0], dw[15:8], dw[23:16]};
        return pal_of(idx);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] idx, input logic [31:0] dw,
                        input logic [31:0] cw, input bit rdy_force, output bit took);
        @(negedge clk);
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        in_valid  = v;
        in_index  = idx;
        in_direct = dw;
        in_ctrl   = cw;
        out_ready = (bp_mode && !rdy_force) ? lfsr[0] : 1'b1;
        #1;
        // R5 palette port follows the input
        if (in_ready) begin
            chk(pal_en == 1'b1, "R5 pal_en", {31'b0, pal_en}, 32'd1);
            chk(pal_addr == in_index, "R5 pal_addr", {24'b0, pal_addr}, {24'b0, in_index});
        end
        // R7 hold after stall
        if (prev_stall && prev_bgr == cfg_bgr) begin
            chk(out_valid && out_pixel == prev_pix, "R7 hold", out_pixel, prev_pix);
        end
        if (out_valid && !out_ready) begin
            chk(!in_ready, "R7 in_ready low", {31'b0, in_ready}, 32'd0);
        end
        prev_stall = out_valid && !out_ready;
        prev_pix   = out_pixel;
        prev_bgr   = cfg_bgr;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8 extra pixel", out_pixel, 32'hFFFF_FFFF);
            end else begin
                logic [23:0] e;
                int a;
                e = exp_q.pop_front();
                a = acc_q.pop_front();
                // R2 R3 R4 R9 R10 colour, source choice and packing
                chk(out_pixel == pack(e, cfg_bgr), "R2/R3/R4/R9/R10 pixel", out_pixel, pack(e, cfg_bgr));
                if (a >= 0) chk(cyc - a == PAL_LAT, "R6 latency", 32'(cyc - a), 32'(PAL_LAT));
            end
        end
        took = v && in_ready;
        if (took) begin
            exp_q.push_back(expect_rgb(idx, dw, cw));
            acc_q.push_back(bp_mode ? -1 : cyc);
        end
    endtask

    task automatic send(input logic [7:0] idx, input logic [31:0] dw, input logic [31:0] cw,
                        input bit gap);
        bit took;
        if (gap) step(1'b0, 8'hEE, 32'hDEAD_BEEF, 32'h0300_0000, 1'b0, took);
        do step(1'b1, idx, dw, cw, 1'b0, took); while (!took);
    endtask

    task automatic drain();
        bit took;
        for (int i = 0; i < 8; i++) step(1'b0, 8'h00, '0, '0, 1'b1, took);
        chk(exp_q.size() == 0, "R8 all pixels out", 32'(exp_q.size()), 32'd0);
        chk(!out_valid, "R8 idle after drain", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin
        bit took;
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid, "R1 out_valid in reset", {31'b0, out_valid}, 32'd0);
        rst = 1'b0;
        step(1'b0, '0, '0, '0, 1'b1, took);
        chk(!out_valid && in_ready, "R1 idle after reset", {30'b0, out_valid, in_ready}, 32'd1);

        // R2 R3: sweep every control top byte, random low bits, free running
        for (int t = 0; t < 256; t++) begin
            send(8'(t * 7), {lfsr, lfsr ^ 16'h3C5A}, {8'(t), lfsr[7:0], 16'(t * 913)}, 1'b0);
        end
        drain();

        // R3: every index on the palette path with noisy direct words
        for (int i = 0; i < 256; i++) begin
            send(8'(i), {lfsr ^ 16'h1234, lfsr}, {8'h02, 24'(i * 4099)}, i[0]);
        end
        drain();

        // R4 R9: direct path with every top byte of the direct word, BGR packing
        cfg_bgr = 1'b1;
        for (int i = 0; i < 256; i++) begin
            send(8'(255 - i), {8'(i), 8'(i ^ 8'h5A), lfsr}, 32'h0300_0000 | 32'(i), 1'b0);
        end
        drain();

        // R7 R8: random backpressure, mixed sources, both packings
        bp_mode = 1'b1;
        for (int i = 0; i < 600; i++) begin
            if (i == 300) cfg_bgr = 1'b0;
            send(8'(lfsr[15:8]), {lfsr, lfsr ^ 16'h0F0F},
                 {(lfsr[1] ? 8'h03 : 8'(lfsr[9:2])), 24'(i)}, lfsr[3]);
        end
        bp_mode = 1'b0;
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule